// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This controller turns a set of numbered power domains on and off when software asks it to. It sits on a simple register bus with an address, write data, a write strobe, a read strobe and registered read data. Software starts a transition by writing a one to a domain's power-on or power-off request register. A per-domain sequencer then spends a fixed number of cycles in a "ramping" state before it settles in the new state. When it settles, it raises that domain's completion flag.

Only one transition can run at a time. A request that arrives while the controller is busy is dropped, and a sticky per-domain error bit records the rejection. Software reads that bit and submits the request again later. Completion flags are write-one-to-clear and are packed 32 domains to a word. Per-word enable and mask registers decide which flags drive the single interrupt output. A flag that is enabled but masked can still be polled without disturbing the CPU.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, every domain status register reads 0x0000_0001 (off), every error register reads 0, the flag, enable and mask words read 0, the global status word reads 0x0000_0003 and `irq` is low.
- R2: The global status word at 0x000 reads 0x3 in bits [1:0] when no domain is ramping and 0x0 in bits [1:0] while any domain is ramping. At most one domain ramps at any time.
- R3: A write with wdata bit 0 = 1 to 0x1000 + 0x40*d + 0x4, made while the controller is idle, starts a power-up of domain d. During the ramp, its status register (0x1000 + 0x40*d) reads 0x0000_1000 (bit 12). Afterwards it reads 0x0000_0010 (bit 4). A request write with wdata bit 0 = 0 has no effect.
- R4: A write with wdata bit 0 = 1 to 0x1000 + 0x40*d + 0x8, made while the controller is idle, starts a power-down. During the ramp, the status register reads 0x0000_0100 (bit 8). Afterwards it reads 0x0000_0001 (bit 0).
- R5: A request written while any domain is ramping is rejected. The target domain's state is unchanged, and bit 0 of its error register (0x1000 + 0x40*d + 0xC) is set and stays set. The next accepted request to that domain clears the bit.
- R6: When domain d finishes a ramp, bit d%32 of flag word 0x810 + 4*(d/32) is set. Writing a 1 to a flag bit clears it. Writing 0 leaves it set.
- R7: Enable words (0x820 + 4*i) and mask words (0x830 + 4*i) are read/write. Bits beyond the last domain read 0.
- R8: `irq` is high exactly when some flag bit is set with its enable bit 1 and its mask bit 0. A masked flag stays readable but keeps `irq` low.
- R9: A ramp lasts exactly RAMP_CYCLES clock cycles after the edge that accepts the request. The new state and the flag appear at the following edge.
- R10: Reads of unmapped addresses, of request registers, or of domains at or above N_DOMAINS return 0. Request writes to such domains start nothing.
- R11: `rd_data` is updated on the clock edge that samples `rd_en` high, and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 16 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; data appears after the next edge |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Completion interrupt: OR of flag AND enable AND NOT mask |

## Verification
The assertions assume that the bus strobes and address are never unknown once the internal reset has been released. They also assume that a request reaches the sequencers only through the address decoder, so the single-ramp invariant depends only on the decoder's busy check. The bench drives every bus input on the falling clock edge and holds it for exactly one cycle. It issues no access until four cycles after reset release. It samples results on the falling edge, so a read always reflects the state left by the previous rising edge.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;

  typedef enum logic [1:0] {
    DS_OFF     = 2'd0,
    DS_RAMP_UP = 2'd1,
    DS_ON      = 2'd2,
    DS_RAMP_DN = 2'd3
  } dom_state_e;

  // status word bit positions read by software
  localparam int unsigned ST_OFF_BIT = 0;
  localparam int unsigned ST_ON_BIT  = 4;
  localparam int unsigned ST_DN_BIT  = 8;
  localparam int unsigned ST_UP_BIT  = 12;

  // address map
  localparam logic [15:0] GLOBAL_ADDR = 16'h0000;
  localparam logic [11:0] FLAG_GRP    = 12'h081;
  localparam logic [11:0] ENA_GRP     = 12'h082;
  localparam logic [11:0] MSK_GRP     = 12'h083;
  localparam logic [3:0]  DOM_REGION  = 4'h1;

  // word offsets within one domain group
  localparam logic [3:0] SUB_STAT = 4'd0;
  localparam logic [3:0] SUB_UP   = 4'd1;
  localparam logic [3:0] SUB_DN   = 4'd2;
  localparam logic [3:0] SUB_ERR  = 4'd3;

  function automatic logic [31:0] state_word(dom_state_e s);
    logic [31:0] w;
    w = '0;
    unique case (s)
      DS_OFF:     w[ST_OFF_BIT] = 1'b1;
      DS_ON:      w[ST_ON_BIT]  = 1'b1;
      DS_RAMP_DN: w[ST_DN_BIT]  = 1'b1;
      DS_RAMP_UP: w[ST_UP_BIT]  = 1'b1;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/psc_dom_seq.sv
`timescale 1ns/1ps
module psc_dom_seq
  import psc_pkg::*;
#(
  parameter int unsigned RAMP_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        go_up,
  output logic        busy,
  output logic        done,
  output logic [31:0] stat
);

  localparam int unsigned CNT_W = (RAMP_CYCLES > 1) ? $clog2(RAMP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RAMP_CYCLES - 1);

  dom_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             adv_en;

  // next state
  always_comb begin
    busy   = (st_q == DS_RAMP_UP) || (st_q == DS_RAMP_DN);
    done   = busy && (cnt_q == '0);
    st_d   = st_q;
    cnt_d  = cnt_q;
    if (start) begin
      st_d  = go_up ? DS_RAMP_UP : DS_RAMP_DN;
      cnt_d = CNT_LOAD;
    end else if (done) begin
      st_d  = (st_q == DS_RAMP_UP) ? DS_ON : DS_OFF;
    end else if (busy) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    adv_en = start | busy;
    stat   = state_word(st_q);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DS_OFF;
      cnt_q <= '0;
    end else if (adv_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R5
  AST_RAMP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(st_q))); // R9
  AST_UP_LANDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (done && st_q == DS_RAMP_UP) |=> stat[ST_ON_BIT]); // R3
  AST_DN_LANDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (done && st_q == DS_RAMP_DN) |=> stat[ST_OFF_BIT]); // R4

endmodule

// File: rtl/psc_flag_bank.sv
`timescale 1ns/1ps
module psc_flag_bank #(
  parameter int unsigned LIVE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] fin,
  input  logic        clr_we,
  input  logic        en_we,
  input  logic        mk_we,
  input  logic [31:0] wdata,
  output logic [31:0] flag_q,
  output logic [31:0] en_q,
  output logic [31:0] mk_q,
  output logic        irq_hit
);

  localparam logic [31:0] LIVE_MASK =
    (LIVE_BITS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << LIVE_BITS) - 32'd1);

  logic [31:0] flag_d, en_d, mk_d;
  logic        flag_en;

  always_comb begin
    flag_d  = ((flag_q & ~(clr_we ? wdata : 32'd0)) | fin) & LIVE_MASK;
    flag_en = clr_we | (|fin);
    en_d    = wdata & LIVE_MASK;
    mk_d    = wdata & LIVE_MASK;
    irq_hit = |(flag_q & en_q & ~mk_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk_q <= '0;
    end else if (mk_we) begin
      mk_q <= mk_d;
    end
  end

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fin & LIVE_MASK)) |=> ((flag_q & $past(fin & LIVE_MASK)) == $past(fin & LIVE_MASK))); // R6
  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hit |-> ((flag_q & ~mk_q) != 32'd0)); // R8
  AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && fin == 32'd0) |=> $stable(flag_q)); // R6

endmodule

// File: rtl/psc_regif.sv
`timescale 1ns/1ps
module psc_regif
  import psc_pkg::*;
#(
  parameter int unsigned N_DOMAINS = 8,
  parameter int unsigned N_WORDS   = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [15:0]                  addr,
  input  logic [31:0]                  wdata,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic                         any_busy,
  input  logic [N_DOMAINS-1:0][31:0]   dom_stat,
  input  logic [N_WORDS-1:0][31:0]     flag_w,
  input  logic [N_WORDS-1:0][31:0]     en_w,
  input  logic [N_WORDS-1:0][31:0]     mk_w,
  output logic [N_DOMAINS-1:0]         start,
  output logic                         go_up,
  output logic [N_WORDS-1:0]           clr_we,
  output logic [N_WORDS-1:0]           en_we,
  output logic [N_WORDS-1:0]           mk_we,
  output logic [31:0]                  rd_data
);

  logic                 dom_sel;
  logic [5:0]           idx;
  logic [3:0]           sub;
  logic [11:0]          grp;
  logic [1:0]           widx;
  logic                 req_hit;
  logic [1:0]           ready;
  logic [N_DOMAINS-1:0] err_q, err_d;
  logic [31:0]          rd_next;

  always_comb begin
    dom_sel = (addr[15:12] == DOM_REGION);
    idx     = addr[11:6];
    sub     = addr[5:2];
    grp     = addr[15:4];
    widx    = addr[3:2];
    ready   = any_busy ? 2'b00 : 2'b11;
    go_up   = (sub == SUB_UP);
    req_hit = 1'b0;
    start   = '0;
    err_d   = err_q;
    for (int d = 0; d < N_DOMAINS; d++) begin
      if (wr_en && dom_sel && idx == 6'(d) &&
          (sub == SUB_UP || sub == SUB_DN) && wdata[0]) begin
        req_hit  = 1'b1;
        start[d] = !any_busy;
        err_d[d] = any_busy;
      end
    end
  end

  always_comb begin
    for (int w = 0; w < N_WORDS; w++) begin
      clr_we[w] = wr_en && grp == FLAG_GRP && widx == 2'(w);
      en_we[w]  = wr_en && grp == ENA_GRP  && widx == 2'(w);
      mk_we[w]  = wr_en && grp == MSK_GRP  && widx == 2'(w);
    end
  end

  // read mux
  always_comb begin
    rd_next = '0;
    if (addr == GLOBAL_ADDR) begin
      rd_next = {30'd0, ready};
    end
    for (int w = 0; w < N_WORDS; w++) begin
      if (widx == 2'(w)) begin
        if (grp == FLAG_GRP) rd_next = flag_w[w];
        if (grp == ENA_GRP)  rd_next = en_w[w];
        if (grp == MSK_GRP)  rd_next = mk_w[w];
      end
    end
    for (int d = 0; d < N_DOMAINS; d++) begin
      if (dom_sel && idx == 6'(d)) begin
        if (sub == SUB_STAT) rd_next = dom_stat[d];
        if (sub == SUB_ERR)  rd_next = {31'd0, err_q[d]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (req_hit) begin
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_next;
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R11
  AST_REJECT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && any_busy) |-> (start == '0)); // R5

  for (genvar g = 0; g < N_DOMAINS; g++) begin : g_err_chk
    AST_REJECT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dom_sel && idx == 6'(g) && (sub == SUB_UP || sub == SUB_DN)
       && wdata[0] && any_busy) |=> err_q[g]); // R5
    AST_ERR_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_hit |=> $stable(err_q[g])); // R5
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import psc_pkg::*;
#(
  parameter int unsigned N_DOMAINS   = 8,
  parameter int unsigned RAMP_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic [31:0] wdata,
  input  logic        wr_en,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        irq
);

  localparam int unsigned N_WORDS = (N_DOMAINS + 31) / 32;

  logic [1:0]                 rst_sync_q;
  logic                       rst_n_i;
  logic [N_DOMAINS-1:0]       start_vec, busy_vec, done_vec;
  logic [N_DOMAINS-1:0][31:0] stat_vec;
  logic                       go_up;
  logic                       any_busy;
  logic [N_WORDS*32-1:0]      done_pad;
  logic [N_WORDS-1:0]         clr_we, en_we, mk_we, irq_hit;
  logic [N_WORDS-1:0][31:0]   flag_w, en_w, mk_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  for (genvar d = 0; d < N_DOMAINS; d++) begin : g_dom
    psc_dom_seq #(.RAMP_CYCLES(RAMP_CYCLES)) u_seq (
      .clk   (clk),
      .rst_n (rst_n_i),
      .start (start_vec[d]),
      .go_up (go_up),
      .busy  (busy_vec[d]),
      .done  (done_vec[d]),
      .stat  (stat_vec[d])
    );
  end

  always_comb begin
    any_busy = |busy_vec;
    done_pad = '0;
    done_pad[N_DOMAINS-1:0] = done_vec;
    irq = |irq_hit;
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    localparam int unsigned REMAIN = N_DOMAINS - w * 32;
    psc_flag_bank #(.LIVE_BITS((REMAIN > 32) ? 32 : REMAIN)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .fin     (done_pad[w*32 +: 32]),
      .clr_we  (clr_we[w]),
      .en_we   (en_we[w]),
      .mk_we   (mk_we[w]),
      .wdata   (wdata),
      .flag_q  (flag_w[w]),
      .en_q    (en_w[w]),
      .mk_q    (mk_w[w]),
      .irq_hit (irq_hit[w])
    );
  end

  psc_regif #(.N_DOMAINS(N_DOMAINS), .N_WORDS(N_WORDS)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .any_busy (any_busy),
    .dom_stat (stat_vec),
    .flag_w   (flag_w),
    .en_w     (en_w),
    .mk_w     (mk_w),
    .start    (start_vec),
    .go_up    (go_up),
    .clr_we   (clr_we),
    .en_we    (en_we),
    .mk_we    (mk_we),
    .rd_data  (rd_data)
  );

  AST_ONE_RAMP: assert property (@(posedge clk) disable iff (!rst_n_i)
    $countones(busy_vec) <= 1); // R2
  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n_i)
    (|start_vec) |=> any_busy); // R2
  AST_DONE_RAISES_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n_i)
    (|done_vec) |=> (|flag_w)); // R6

endmodule

// File: tb/tb_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_seq_ctrl;

  localparam int unsigned NDOM = 8;
  localparam int unsigned RAMP = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic [31:0] wdata;
  logic        wr_en, rd_en;
  logic [31:0] rd_data;
  logic        irq;

  int nvec = 0;
  int nbad = 0;
  bit finished = 0;

  pwr_seq_ctrl #(.N_DOMAINS(NDOM), .RAMP_CYCLES(RAMP)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] dreg(int d, int sub);
    return 16'(32'h1000 + d * 32'h40 + sub * 4);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // both tasks start and end on a falling edge
  task automatic wr(logic [15:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic settle();
    repeat (RAMP + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(16'h0000, v);     chk("R1 global", v, 32'h3);
    rd(dreg(0, 0), v);   chk("R1 status d0", v, 32'h1);
    rd(dreg(7, 0), v);   chk("R1 status d7", v, 32'h1);
    rd(dreg(4, 3), v);   chk("R1 error d4", v, 32'h0);
    rd(16'h0810, v);     chk("R1 flags", v, 32'h0);
    rd(16'h0820, v);     chk("R1 enable", v, 32'h0);
    rd(16'h0830, v);     chk("R1 mask", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_power_up();
    logic [31:0] v;
    wr(dreg(2, 1), 32'h1);                      // accepted at edge k
    rd(16'h0000, v);   chk("R2 busy", v, 32'h0); // edge k+1
    rd(dreg(2, 0), v); chk("R3 ramp up", v, 32'h1000); // edge k+2
    repeat (RAMP - 3) @(negedge clk);
    rd(dreg(2, 0), v); chk("R9 last ramp cycle", v, 32'h1000); // edge k+RAMP
    rd(dreg(2, 0), v); chk("R9 R3 on", v, 32'h10);
    rd(16'h0000, v);   chk("R2 ready", v, 32'h3);
    rd(16'h0810, v);   chk("R6 flag d2", v, 32'h4);
    chk("R8 irq disabled", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_ignore_zero();
    logic [31:0] v;
    wr(dreg(3, 1), 32'h0);
    rd(16'h0000, v);   chk("R3 zero write global", v, 32'h3);
    rd(dreg(3, 0), v); chk("R3 zero write status", v, 32'h1);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(16'h0810, 32'h0);
    rd(16'h0810, v);   chk("R6 write zero keeps", v, 32'h4);
    wr(16'h0810, 32'h4);
    rd(16'h0810, v);   chk("R6 w1c", v, 32'h0);
  endtask

  task automatic t_reject();
    logic [31:0] v;
    wr(dreg(1, 1), 32'h1);
    wr(dreg(5, 1), 32'h1);                       // rejected
    rd(dreg(5, 3), v); chk("R5 error set", v, 32'h1);
    rd(dreg(5, 0), v); chk("R5 target unchanged", v, 32'h1);
    settle();
    rd(dreg(1, 0), v); chk("R3 d1 on", v, 32'h10);
    rd(dreg(5, 0), v); chk("R5 still off", v, 32'h1);
    rd(dreg(5, 3), v); chk("R5 error sticky", v, 32'h1);
    wr(dreg(5, 1), 32'h1);                       // retry accepted
    rd(dreg(5, 3), v); chk("R5 error cleared", v, 32'h0);
    settle();
    rd(dreg(5, 0), v); chk("R5 retry on", v, 32'h10);
    rd(16'h0810, v);   chk("R6 flags d1 d5", v, 32'h22);
    wr(16'h0810, 32'h22);
    rd(16'h0810, v);   chk("R6 clear both", v, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(16'h0820, 32'hFFFF_FF04);
    rd(16'h0820, v);   chk("R7 enable readback", v, 32'h04);
    wr(16'h0830, 32'h0000_0004);
    rd(16'h0830, v);   chk("R7 mask readback", v, 32'h04);
    wr(dreg(2, 2), 32'h1);
    rd(dreg(2, 0), v); chk("R4 ramp down", v, 32'h100);
    settle();
    rd(dreg(2, 0), v); chk("R4 off", v, 32'h1);
    rd(16'h0810, v);   chk("R8 masked flag visible", v, 32'h4);
    chk("R8 masked irq low", {31'd0, irq}, 32'h0);
    wr(16'h0830, 32'h0);
    chk("R8 unmasked irq high", {31'd0, irq}, 32'h1);
    wr(16'h0810, 32'h4);
    chk("R8 cleared irq low", {31'd0, irq}, 32'h0);
    wr(16'h0820, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(dreg(NDOM, 0), v); chk("R10 missing domain read", v, 32'h0);
    wr(dreg(NDOM, 1), 32'h1);
    rd(16'h0000, v);      chk("R10 missing domain no start", v, 32'h3);
    rd(16'h0004, v);      chk("R10 hole read", v, 32'h0);
    rd(dreg(0, 1), v);    chk("R10 request reg reads zero", v, 32'h0);
  endtask

  task automatic t_rd_hold();
    logic [31:0] v;
    wr(dreg(6, 1), 32'h1);
    rd(dreg(6, 0), v); chk("R11 read in ramp", v, 32'h1000);
    settle();
    chk("R11 rd_data held", rd_data, 32'h1000);
    rd(dreg(6, 0), v); chk("R11 fresh read", v, 32'h10);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_power_up();
    t_ignore_zero();
    t_w1c();
    t_reject();
    t_mask();
    t_unmapped();
    t_rd_hold();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule